// File: doc/BRIEF.md
# Configurable Serial Byte Shifter

This block moves one byte over a three-wire synchronous serial link for each start command. It can generate the serial clock itself or follow a clock that arrives on a pin. Software sets the clock idle level, the clock edge that captures data, and whether the least or the most significant bit goes first. Software loads the outgoing byte into a data buffer and then sets the start bit. The same buffer shifts in place, so after the transfer it holds the byte that was received.

When the block generates the clock, the half-period comes from two stages. A power-of-two prescaler is chosen by a two-bit rate field. After it, a reloadable down-counter acts as a post-scaler: when it reaches zero it produces a clock edge and takes the reload value again. When the block follows an external clock, the pin clock is synchronised to the system clock and the rate fields have no effect. After the sixteenth serial clock edge the start bit clears by itself and an interrupt flag rises. The flag falls again when the next transfer is accepted.

Register access is a simple write strobe with an address, plus a combinational read port. Register addresses:
- 0: mode.
- 1: data buffer.
- 2: reload.

Mode register bit layout:
- bit 7: enable.
- bit 6: start, which also reads as busy.
- bit 5: clock master when 1.
- bit 4: least significant bit first when 1.
- bit 3: clock idle level.
- bit 2: phase, where 1 means capture on the second edge of each bit.
- bits 1:0: prescaler exponent.

Top module: `sershift_top`

## Requirements
- R1: After reset the mode, data and reload registers read 0, irq is 0, and sclkOut and sclkOe are 0.
- R2: While no transfer is running, sclkOut equals the clock idle level written in mode bit 3, and it returns to that level after a transfer.
- R3: In master mode, consecutive sclkOut transitions are spaced (reload+1)·2^sel system clock cycles apart, where sel is mode bits 1:0.
- R4: A transfer accepted in master mode produces exactly 16 sclkOut transitions (8 clock periods).
- R5: With phase 0, sdo presents the first bit before the first clock edge and changes only on second edges; sdi is captured on first edges.
- R6: With phase 1, sdo changes on first edges and sdi is captured on second edges.
- R7: With mode bit 4 set, bits leave and arrive least significant first; otherwise most significant first.
- R8: At the end of a transfer the data buffer holds the received byte and the start bit reads 0.
- R9: irq rises when the eighth bit completes and falls when the next start is accepted.
- R10: While a transfer runs, writes to the mode register (including a new start) and to the data buffer are ignored.
- R11: In slave mode the clock is taken from sclkIn, sclkOe stays 0, and the byte still transfers with the same phase and order rules.
- R12: Writing start with the enable bit clear starts nothing: the start bit reads 0 and sclkOut does not toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write address |
| wrData | input | 8 | Write data |
| rdAddr | input | 2 | Read address |
| rdData | output | 8 | Read data (combinational) |
| sclkIn | input | 1 | Serial clock from pin (slave mode) |
| sclkOut | output | 1 | Serial clock driven in master mode |
| sclkOe | output | 1 | Serial clock output enable |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| irq | output | 1 | End-of-transfer flag |

## Verification
Suppose the edge counter is wrong. The clock line then shows too many or too few transitions, and the start bit clears early or late. Either shows up within one transfer. Suppose the prescaler or post-scaler is wrong. The spacing of the second sclkOut transition is then already off. Suppose the output-bit register or the capture strobe is wrong. The bench's model slave then sees a different transmitted sequence, and the read-back buffer differs from the driven pattern as soon as the byte completes. A lock that fails to hold shows up differently: a mid-transfer write either changes the clock count or shows in the mode read-back.

// File: rtl/sershift_pkg.sv
package sershift_pkg;

  localparam int unsigned REG_MODE   = 0;
  localparam int unsigned REG_DATA   = 1;
  localparam int unsigned REG_RELOAD = 2;

  typedef struct packed {
    logic       enable;
    logic       start;
    logic       master;
    logic       lsbFirst;
    logic       cpol;
    logic       cpha;
    logic [1:0] rateSel;
  } modeReg_t;

  typedef struct packed {
    logic loadBuf;
    logic startXfer;
    logic sampleIn;
    logic shiftBuf;
    logic driveCur;
    logic driveNext;
    logic xferDone;
  } xferStrobe_t;

endpackage

// File: rtl/sershift_clkgen.sv
module sershift_clkgen #(
  parameter int RATE_W = 2,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              run,
  input  logic [RATE_W-1:0] rateSel,
  input  logic [CNT_W-1:0]  reload,
  output logic              tick
);
  localparam int PRE_W = (1 << RATE_W) - 1;

  logic [PRE_W-1:0] preCnt;
  logic [PRE_W:0]   preSpan;
  logic [PRE_W-1:0] preMask;
  logic             preTick;
  logic [CNT_W-1:0] postCnt;

  always_comb begin
    preSpan = ({{PRE_W{1'b0}}, 1'b1} << rateSel) - 1'b1;
    preMask = preSpan[PRE_W-1:0];
  end

  assign preTick = run && (preCnt == preMask);
  assign tick    = preTick && (postCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (!run || preTick) begin
      preCnt <= '0;
    end else begin
      preCnt <= preCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      postCnt <= '0;
    end else if (!run) begin
      postCnt <= reload;
    end else if (preTick) begin
      postCnt <= (postCnt == '0) ? reload : postCnt - 1'b1;
    end
  end
endmodule

// File: rtl/sershift_ctrl.sv
module sershift_ctrl
  import sershift_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              sclkIn,
  input  logic              masterTick,
  output modeReg_t          modeQ,
  output logic [DATA_W-1:0] reloadVal,
  output xferStrobe_t       str,
  output logic              lsbEff,
  output logic              busy,
  output logic              irq,
  output logic              sclkOut,
  output logic              sclkOe,
  output logic              runMaster
);
  localparam int EDGES = 2 * DATA_W;
  localparam int EC_W  = $clog2(EDGES);

  modeReg_t          wrMode;
  logic              modeWr;
  logic              acceptStart;
  logic [EC_W-1:0]   edgeCnt;
  logic [SYNC_N-1:0] syncQ;
  logic              prevLvl;
  logic              slaveEdge;
  logic              edgeEv;
  logic              leadEdge;

  assign wrMode      = modeReg_t'(wrData[7:0]);
  assign busy        = modeQ.start;
  assign modeWr      = wrEn && (wrAddr == ADDR_W'(REG_MODE)) && !busy;
  assign acceptStart = modeWr && wrMode.start && wrMode.enable;
  assign runMaster   = busy && modeQ.master;
  assign sclkOe      = modeQ.master && modeQ.enable;
  assign lsbEff      = acceptStart ? wrMode.lsbFirst : modeQ.lsbFirst;

  // pin clock synchroniser and edge detect
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ   <= '0;
      prevLvl <= 1'b0;
    end else begin
      syncQ   <= {syncQ[SYNC_N-2:0], sclkIn};
      prevLvl <= syncQ[SYNC_N-1];
    end
  end
  assign slaveEdge = syncQ[SYNC_N-1] ^ prevLvl;

  assign edgeEv   = busy && (modeQ.master ? masterTick : slaveEdge);
  assign leadEdge = ~edgeCnt[0];

  always_comb begin
    str           = '0;
    str.loadBuf   = wrEn && (wrAddr == ADDR_W'(REG_DATA)) && !busy;
    str.startXfer = acceptStart;
    str.sampleIn  = edgeEv && (leadEdge ^ modeQ.cpha);
    str.shiftBuf  = edgeEv && !leadEdge;
    str.driveCur  = edgeEv && leadEdge && modeQ.cpha;
    str.driveNext = edgeEv && !leadEdge && !modeQ.cpha;
    str.xferDone  = edgeEv && (edgeCnt == EC_W'(EDGES - 1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= '0;
    end else if (modeWr) begin
      modeQ       <= wrMode;
      modeQ.start <= acceptStart;
    end else if (str.xferDone) begin
      modeQ.start <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reloadVal <= '0;
    end else if (wrEn && (wrAddr == ADDR_W'(REG_RELOAD))) begin
      reloadVal <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      edgeCnt <= '0;
    end else if (acceptStart) begin
      edgeCnt <= '0;
    end else if (edgeEv) begin
      edgeCnt <= edgeCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkOut <= 1'b0;
    end else if (modeWr) begin
      sclkOut <= wrMode.cpol;
    end else if (edgeEv && modeQ.master) begin
      sclkOut <= ~sclkOut;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irq <= 1'b0;
    end else if (acceptStart) begin
      irq <= 1'b0;
    end else if (str.xferDone) begin
      irq <= 1'b1;
    end
  end
endmodule

// File: rtl/sershift_dp.sv
module sershift_dp
  import sershift_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  xferStrobe_t       str,
  input  logic [DATA_W-1:0] wrData,
  input  logic              lsbFirst,
  input  logic              sdiPin,
  output logic [DATA_W-1:0] bufQ,
  output logic              sdoOut
);
  logic              heldBit;
  logic              inBit;
  logic [DATA_W-1:0] shifted;
  logic              curOut;
  logic              nextOut;

  assign inBit = str.sampleIn ? sdiPin : heldBit;

  always_comb begin
    if (lsbFirst) begin
      shifted = {inBit, bufQ[DATA_W-1:1]};
      curOut  = bufQ[0];
      nextOut = shifted[0];
    end else begin
      shifted = {bufQ[DATA_W-2:0], inBit};
      curOut  = bufQ[DATA_W-1];
      nextOut = shifted[DATA_W-1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufQ <= '0;
    end else if (str.loadBuf) begin
      bufQ <= wrData;
    end else if (str.shiftBuf) begin
      bufQ <= shifted;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldBit <= 1'b0;
    end else if (str.sampleIn) begin
      heldBit <= sdiPin;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sdoOut <= 1'b0;
    end else if (str.startXfer || str.driveCur) begin
      sdoOut <= curOut;
    end else if (str.driveNext) begin
      sdoOut <= nextOut;
    end
  end
endmodule

// File: rtl/sershift_top.sv
module sershift_top
  import sershift_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2,
  parameter int RATE_W = 2,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic              sclkIn,
  output logic              sclkOut,
  output logic              sclkOe,
  input  logic              sdi,
  output logic              sdo,
  output logic              irq
);
  modeReg_t          modeQ;
  xferStrobe_t       str;
  logic [DATA_W-1:0] reloadVal;
  logic [DATA_W-1:0] bufQ;
  logic              lsbEff;
  logic              busy;
  logic              runMaster;
  logic              masterTick;

  sershift_clkgen #(.RATE_W(RATE_W), .CNT_W(DATA_W)) i_clkgen (
    .clk(clk), .rstN(rstN), .run(runMaster), .rateSel(modeQ.rateSel),
    .reload(reloadVal), .tick(masterTick)
  );

  sershift_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SYNC_N(SYNC_N)) i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .sclkIn(sclkIn), .masterTick(masterTick), .modeQ(modeQ),
    .reloadVal(reloadVal), .str(str), .lsbEff(lsbEff), .busy(busy),
    .irq(irq), .sclkOut(sclkOut), .sclkOe(sclkOe), .runMaster(runMaster)
  );

  sershift_dp #(.DATA_W(DATA_W)) i_dp (
    .clk(clk), .rstN(rstN), .str(str), .wrData(wrData), .lsbFirst(lsbEff),
    .sdiPin(sdi), .bufQ(bufQ), .sdoOut(sdo)
  );

  always_comb begin
    if (rdAddr == ADDR_W'(REG_MODE)) begin
      rdData = DATA_W'(modeQ);
    end else if (rdAddr == ADDR_W'(REG_DATA)) begin
      rdData = bufQ;
    end else if (rdAddr == ADDR_W'(REG_RELOAD)) begin
      rdData = reloadVal;
    end else begin
      rdData = '0;
    end
  end
endmodule

// File: rtl/sershift_chk.sv
module sershift_chk
  import sershift_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input modeReg_t    modeQ,
  input xferStrobe_t str,
  input logic        busy,
  input logic        irq,
  input logic        sclkOut,
  input logic        sclkOe
);
  p_idle_level_r2: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> sclkOut == modeQ.cpol);

  p_no_drive_slave_r11: assert property (@(posedge clk) disable iff (!rstN)
    !modeQ.master |-> !sclkOe);

  p_irq_set_r9: assert property (@(posedge clk) disable iff (!rstN)
    str.xferDone |=> irq);

  p_irq_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    str.startXfer |=> !irq);

  p_start_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    str.xferDone |=> !busy);

  p_cfg_locked_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !str.xferDone) |=> ($stable({modeQ.enable, modeQ.master, modeQ.lsbFirst,
                                          modeQ.cpol, modeQ.cpha, modeQ.rateSel}) && busy));
endmodule

bind sershift_top sershift_chk i_chk (
  .clk(clk), .rstN(rstN), .modeQ(modeQ), .str(str), .busy(busy),
  .irq(irq), .sclkOut(sclkOut), .sclkOe(sclkOe)
);

// File: tb/test_sershift_top.sv
module test_sershift_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [1:0] rdAddr = '0;
  logic [7:0] rdData;
  logic       sclkIn = 1'b0;
  logic       sclkOut;
  logic       sclkOe;
  logic       sdi = 1'b0;
  logic       sdo;
  logic       irq;

  int totalChecks = 0;
  int badChecks   = 0;
  bit finished    = 0;

  sershift_top i_sershift_top (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .sclkIn(sclkIn), .sclkOut(sclkOut),
    .sclkOe(sclkOe), .sdi(sdi), .sdo(sdo), .irq(irq)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    totalChecks++;
    if (!ok) begin
      badChecks++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mkMode(input bit en, input bit st, input bit mst,
                                        input bit lsb, input bit cpol, input bit cpha,
                                        input logic [1:0] sel);
    return {en, st, mst, lsb, cpol, cpha, sel};
  endfunction

  function automatic bit bitOf(input logic [7:0] b, input int k, input bit lsb);
    return lsb ? b[k] : b[7-k];
  endfunction

  task automatic wrReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [1:0] a, output logic [7:0] v);
    rdAddr = a;
    #1;
    v = rdData;
  endtask

  task automatic masterXfer(input logic [7:0] tx, input logic [7:0] rx, input bit lsb,
                            input bit cpol, input bit cpha, input logic [1:0] sel,
                            input logic [7:0] reload, input bit midWrite);
    int edges = 0;
    int cyc = 0;
    int lastT = 0;
    int expHalf;
    int badGap = 0;
    bit lastLvl;
    bit done = 0;
    bit midMode = 0;
    bit midData = 0;
    bit oeLow = 0;
    logic [7:0] gotSeq = '0;
    logic [7:0] expSeq;
    logic [7:0] v;
    logic [7:0] modeVal;
    string tagPh;
    expHalf = (int'(reload) + 1) << sel;
    tagPh = cpha ? "R6" : "R5";
    for (int k = 0; k < 8; k++) expSeq[k] = bitOf(tx, k, lsb);
    modeVal = mkMode(1, 1, 1, lsb, cpol, cpha, sel);
    wrReg(2, reload);
    wrReg(1, tx);
    sdi = cpha ? 1'b0 : bitOf(rx, 0, lsb);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 0; wrData = modeVal;
    lastLvl = cpol;
    while (!done && cyc < 4000) begin
      @(negedge clk);
      wrEn = 1'b0;
      cyc++;
      if (cyc == 1) chk(irq == 1'b0, "R9 irq cleared at start", irq, 0);
      if (!sclkOe) oeLow = 1;
      if (midWrite && edges == 3 && !midMode) begin
        midMode = 1;
        wrEn = 1'b1; wrAddr = 0; wrData = mkMode(1, 1, 1, ~lsb, ~cpol, ~cpha, ~sel);
      end else if (midWrite && edges == 5 && !midData) begin
        midData = 1;
        wrEn = 1'b1; wrAddr = 1; wrData = ~rx;
      end
      if (sclkOut != lastLvl) begin
        int k;
        bit lead;
        lastLvl = sclkOut;
        if (edges > 0 && (cyc - lastT) != expHalf) badGap = cyc - lastT;
        lastT = cyc;
        k = edges / 2;
        lead = (edges % 2) == 0;
        if (k < 8 && (lead != cpha)) gotSeq[k] = sdo;
        if (cpha && lead && k < 8) sdi = bitOf(rx, k, lsb);
        if (!cpha && !lead && k < 7) sdi = bitOf(rx, k + 1, lsb);
        edges++;
      end
      if (irq && edges > 0) done = 1;
    end
    wrEn = 1'b0;
    chk(edges == 16, "R4 clock transitions", edges, 16);
    chk(badGap == 0, "R3 half period", badGap, expHalf);
    chk(gotSeq == expSeq, lsb ? {tagPh, "/R7 tx lsb first"} : {tagPh, "/R7 tx msb first"},
        gotSeq, expSeq);
    rdReg(1, v);
    chk(v == rx, {tagPh, "/R8 received byte"}, v, rx);
    rdReg(0, v);
    chk(v == mkMode(1, 0, 1, lsb, cpol, cpha, sel), midWrite ? "R10 mode unchanged" : "R8 start cleared",
        v, mkMode(1, 0, 1, lsb, cpol, cpha, sel));
    chk(irq == 1'b1, "R9 irq raised", irq, 1);
    chk(sclkOut == cpol, "R2 idle after transfer", sclkOut, cpol);
    chk(!oeLow, "R11 master drives clock", oeLow, 0);
  endtask

  task automatic slaveXfer(input logic [7:0] tx, input logic [7:0] rx, input bit lsb,
                           input bit cpol, input bit cpha);
    logic [7:0] gotSeq = '0;
    logic [7:0] expSeq;
    logic [7:0] v;
    bit oeHigh = 0;
    int toggles = 0;
    bit lastLvl;
    for (int k = 0; k < 8; k++) expSeq[k] = bitOf(tx, k, lsb);
    sclkIn = cpol;
    wrReg(1, tx);
    sdi = cpha ? 1'b0 : bitOf(rx, 0, lsb);
    repeat (4) @(negedge clk);
    wrReg(0, mkMode(1, 1, 0, lsb, cpol, cpha, 2'd3));
    lastLvl = sclkOut;
    repeat (4) @(negedge clk);
    for (int e = 0; e < 16; e++) begin
      int k = e / 2;
      bit lead = (e % 2) == 0;
      if (lead != cpha) gotSeq[k] = sdo;
      sclkIn = ~sclkIn;
      if (cpha && lead) sdi = bitOf(rx, k, lsb);
      if (!cpha && !lead && k < 7) sdi = bitOf(rx, k + 1, lsb);
      repeat (8) begin
        @(negedge clk);
        if (sclkOe) oeHigh = 1;
        if (sclkOut != lastLvl) begin toggles++; lastLvl = sclkOut; end
      end
    end
    repeat (4) @(negedge clk);
    chk(!oeHigh && toggles == 0, "R11 slave does not drive clock", toggles, 0);
    chk(gotSeq == expSeq, "R11 slave transmit sequence", gotSeq, expSeq);
    rdReg(1, v);
    chk(v == rx, "R11 slave received byte", v, rx);
    chk(irq == 1'b1, "R11 slave irq", irq, 1);
    rdReg(0, v);
    chk(v[6] == 1'b0, "R11 slave start cleared", v[6], 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      totalChecks++;
      badChecks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", totalChecks, badChecks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int seedJunk;
    int tog;
    bit lvl;
    seedJunk = $urandom(32'h1D2C);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    rdReg(0, v); chk(v == 8'h00, "R1 mode reset", v, 0);
    rdReg(1, v); chk(v == 8'h00, "R1 data reset", v, 0);
    rdReg(2, v); chk(v == 8'h00, "R1 reload reset", v, 0);
    chk(irq == 1'b0 && sclkOut == 1'b0 && sclkOe == 1'b0, "R1 outputs reset",
        {irq, sclkOut, sclkOe}, 0);

    // R2: idle level follows polarity without a transfer
    wrReg(0, mkMode(1, 0, 1, 0, 1, 0, 0));
    chk(sclkOut == 1'b1, "R2 idle level high", sclkOut, 1);
    wrReg(0, mkMode(1, 0, 1, 0, 0, 0, 0));
    chk(sclkOut == 1'b0, "R2 idle level low", sclkOut, 0);

    // R12: start without enable
    wrReg(0, mkMode(0, 1, 1, 0, 0, 0, 0));
    rdReg(0, v);
    chk(v[6] == 1'b0, "R12 start ignored when disabled", v[6], 0);
    tog = 0; lvl = sclkOut;
    repeat (40) begin
      @(negedge clk);
      if (sclkOut != lvl) begin tog++; lvl = sclkOut; end
    end
    chk(tog == 0 && irq == 1'b0, "R12 no clock when disabled", tog, 0);

    // directed corners
    masterXfer(8'hA5, 8'h3C, 0, 0, 0, 2'd0, 8'd0, 0);
    masterXfer(8'h81, 8'hE7, 1, 1, 1, 2'd3, 8'd3, 0);
    masterXfer(8'h5E, 8'hB2, 0, 1, 0, 2'd1, 8'd2, 1);
    masterXfer(8'h0F, 8'hF0, 1, 0, 1, 2'd2, 8'd0, 0);

    // random master transfers
    for (int i = 0; i < 10; i++) begin
      logic [7:0] t, r, rl;
      logic [3:0] c;
      t = 8'($urandom); r = 8'($urandom); rl = 8'($urandom % 6); c = 4'($urandom);
      masterXfer(t, r, c[0], c[1], c[2], {c[3], c[0] ^ c[1]}, rl, 0);
    end

    // slave transfers
    slaveXfer(8'hC3, 8'h5A, 0, 0, 0);
    slaveXfer(8'h96, 8'h1E, 1, 1, 1);
    for (int i = 0; i < 4; i++) begin
      logic [2:0] c;
      c = 3'($urandom);
      slaveXfer(8'($urandom), 8'($urandom), c[0], c[1], c[2]);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", totalChecks, badChecks);
    $finish;
  end
endmodule